// File: doc/BRIEF.md
# Configurable Logic Slice

This block is a behavioural model of one programmable logic slice. Two 4-input look-up tables take their truth tables from configuration bits; a pair of wide multiplexers joins their outputs into 5- and 6-input functions, with the second one also reaching a wide-function output from the neighbouring slice. A two-stage carry path turns the tables into propagate terms. It has a sum XOR, a carry multiplexer, and a generate selector that takes either an operand bit or the AND of two operand bits, for partial-product arithmetic.

Each of the two result bits feeds a storage element. The element can be configured as an edge-triggered flip-flop or a transparent-high latch. Both elements share a clock enable, an initialise control and an invert-initialise control, and these act either at the clock edge or at once. A per-bit bypass chooses whether the registered or the combinational value reaches the registered output. Four feedthrough wires cross the slice with no logic on them.

Before use, the configuration is loaded one bit per clock through a serial port, most significant bit first. After that the slice acts as a fixed function of its data inputs.

Top module: `logic_slice`

## Requirements
- R1: While `cfg_en_i` is high, each rising edge shifts `cfg_bit_i` into a 43-bit configuration word, most significant bit first. The word layout is: [42:27] Y table, [26:11] X table, [10] wide5_en, [9] wide6_en, [8] carry_en, [7] mult_en, [6:5] latch mode (bit 6 for Y, bit 5 for X), [4] sync_force, [3:2] init value (bit 3 Y, bit 2 X), [1:0] bypass (bit 1 Y, bit 0 X). While `cfg_en_i` is low the word holds.
- R2: With carry_en, wide5_en and wide6_en all 0, `x_o` equals X table bit number `f_in_i` and `y_o` equals Y table bit number `g_in_i`.
- R3: `f5_o` is the Y table output when `f5_sel_i` is 1 and the X table output otherwise. With wide5_en=1 and carry_en=0, `x_o` equals `f5_o`.
- R4: With wide6_en=1 and carry_en=0, `y_o` equals `f5_nbr_i` when `f6_sel_i` is 1 and the own wide-5 value otherwise.
- R5: With carry_en=1, stage 0 uses the X table output p0, with operands `f_in_i[0]`/`f_in_i[1]`; stage 1 uses the Y table output p1, with operands `g_in_i[0]`/`g_in_i[1]`. The generate term is operand 0, or operand0 AND operand1 when mult_en=1. Each stage's sum is p XOR carry-in and its carry-out is carry-in if p else the generate term. `x_o` and `y_o` carry the sums and `cout_o` carries the stage-1 carry. With carry_en=0, `cout_o` is 0.
- R6: In flip-flop mode (latch bit 0) with bypass 0, the registered output takes the combinational result at a rising edge when `ce_i` is high, holds when it is low, and does not change between edges. With bypass 1 it shows the combinational result.
- R7: In latch mode, the registered output follows the combinational result while the clock is high and `ce_i` is high, and holds while the clock is low.
- R8: With sync_force=1, `sr_i` forces the element to its init value at a rising edge regardless of `ce_i`. `by_i` forces the inverse of the init value. When both are high, `sr_i` wins.
- R9: With sync_force=0, `sr_i` and `by_i` force the same values at once, with no clock edge, and `sr_i` still wins.
- R10: `thru_o` always equals `thru_i`.
- R11: While `rst_ni` is low, the configuration word and both storage elements are cleared to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_en_i | input | 1 | Configuration shift enable |
| cfg_bit_i | input | 1 | Serial configuration data |
| f_in_i | input | 4 | X table inputs |
| g_in_i | input | 4 | Y table inputs |
| f5_sel_i | input | 1 | Wide-5 select |
| f6_sel_i | input | 1 | Wide-6 select |
| f5_nbr_i | input | 1 | Wide-5 result from neighbouring slice |
| cin_i | input | 1 | Carry in |
| ce_i | input | 1 | Shared clock enable |
| sr_i | input | 1 | Force to init value |
| by_i | input | 1 | Force to inverse init value |
| thru_i | input | 4 | Feedthrough inputs |
| x_o | output | 1 | X combinational result |
| y_o | output | 1 | Y combinational result |
| xq_o | output | 1 | X registered or bypassed result |
| yq_o | output | 1 | Y registered or bypassed result |
| f5_o | output | 1 | Own wide-5 result to neighbour |
| cout_o | output | 1 | Carry out |
| thru_o | output | 4 | Feedthrough outputs |

## Verification
The table path is swept over all 256 input pairs with asymmetric truth tables, so a reversed index or a swapped table shows up. The wide multiplexers are swept over every combination of table inputs, both selects and the neighbour input, which separates the wide-5 and wide-6 select roles. The carry path is swept twice: once as a 2-bit adder, checked against integer addition, and once with the AND generate term as a partial-product summer. Every pair of force controls is checked in both the edge-timed and the immediate mode, alongside enable patterns for the flip-flop and the open and closed phases of the latch.

// File: rtl/slice_pkg.sv
`timescale 1ns/1ps
package slice_pkg;
  parameter int SLICE_LUT_K  = 4;
  parameter int SLICE_STAGES = 2;
  localparam int SLICE_LUT_W = 1 << SLICE_LUT_K;

  typedef struct packed {
    logic [SLICE_LUT_W-1:0]  lut_g;
    logic [SLICE_LUT_W-1:0]  lut_f;
    logic                    wide5_en;
    logic                    wide6_en;
    logic                    carry_en;
    logic                    mult_en;
    logic [SLICE_STAGES-1:0] latch;
    logic                    sync_force;
    logic [SLICE_STAGES-1:0] init;
    logic [SLICE_STAGES-1:0] bypass;
  } slice_cfg_t;

  localparam int SLICE_CFG_W = $bits(slice_cfg_t);
endpackage

// File: rtl/slice_cfg_shift.sv
`timescale 1ns/1ps
module slice_cfg_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         bit_i,
  output logic [W-1:0] cfg_o
);
  logic [W-1:0] cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (en_i) cfg_q <= {cfg_q[W-2:0], bit_i};
  end

  assign cfg_o = cfg_q;

  assert_shift_in_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> cfg_q[0] == $past(bit_i));
  assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(cfg_q));
endmodule

// File: rtl/slice_lut.sv
`timescale 1ns/1ps
module slice_lut #(
  parameter int K = 4,
  localparam int W = 1 << K
) (
  input  logic [W-1:0] tbl_i,
  input  logic [K-1:0] sel_i,
  output logic         out_o
);
  assign out_o = tbl_i[sel_i];
endmodule

// File: rtl/slice_carry.sv
`timescale 1ns/1ps
module slice_carry #(
  parameter int N = 2
) (
  input  logic [N-1:0] prop_i,
  input  logic [N-1:0] opa_i,
  input  logic [N-1:0] opb_i,
  input  logic         cin_i,
  input  logic         mult_en_i,
  input  logic         carry_en_i,
  output logic [N-1:0] sum_o,
  output logic         cout_o
);
  logic [N:0]   c;
  logic [N-1:0] gen;

  assign c[0] = cin_i;

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign gen[k]   = mult_en_i ? (opa_i[k] & opb_i[k]) : opa_i[k];
    assign c[k+1]   = prop_i[k] ? c[k] : gen[k];
    assign sum_o[k] = prop_i[k] ^ c[k];
  end

  assign cout_o = carry_en_i & c[N];
endmodule

// File: rtl/slice_store.sv
`timescale 1ns/1ps
module slice_store (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  input  logic ce_i,
  input  logic sr_i,
  input  logic by_i,
  input  logic latch_i,
  input  logic sync_i,
  input  logic init_i,
  output logic q_o
);
  logic frc, fval, a_one, a_zero;
  logic ff_q, lat_q;

  assign frc    = sr_i | by_i;
  assign fval   = sr_i ? init_i : ~init_i;  // sr has priority
  assign a_one  = ~sync_i & frc & fval;
  assign a_zero = ~sync_i & frc & ~fval;

  always_ff @(posedge clk_i or negedge rst_ni or posedge a_one or posedge a_zero) begin
    if (!rst_ni)     ff_q <= 1'b0;
    else if (a_one)  ff_q <= 1'b1;
    else if (a_zero) ff_q <= 1'b0;
    else if (frc)    ff_q <= fval;
    else if (ce_i)   ff_q <= d_i;
  end

  always_latch begin
    if (!rst_ni)                     lat_q <= 1'b0;
    else if (frc && (!sync_i || clk_i)) lat_q <= fval;
    else if (clk_i && ce_i)          lat_q <= d_i;
  end

  assign q_o = latch_i ? lat_q : ff_q;

  assert_sync_sr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && sr_i) |=> ff_q == $past(init_i));
  assert_sync_by_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && by_i && !sr_i) |=> ff_q == !$past(init_i));
  assert_ce_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i && !ce_i && !sr_i && !by_i) |=> $stable(ff_q));
endmodule

// File: rtl/logic_slice.sv
`timescale 1ns/1ps
module logic_slice
  import slice_pkg::*;
#(
  parameter int NTHRU = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   cfg_en_i,
  input  logic                   cfg_bit_i,
  input  logic [SLICE_LUT_K-1:0] f_in_i,
  input  logic [SLICE_LUT_K-1:0] g_in_i,
  input  logic                   f5_sel_i,
  input  logic                   f6_sel_i,
  input  logic                   f5_nbr_i,
  input  logic                   cin_i,
  input  logic                   ce_i,
  input  logic                   sr_i,
  input  logic                   by_i,
  input  logic [NTHRU-1:0]       thru_i,
  output logic                   x_o,
  output logic                   y_o,
  output logic                   xq_o,
  output logic                   yq_o,
  output logic                   f5_o,
  output logic                   cout_o,
  output logic [NTHRU-1:0]       thru_o
);
  logic [SLICE_CFG_W-1:0]  cfg_vec;
  slice_cfg_t              cfg;
  logic [SLICE_LUT_W-1:0]  tbl [SLICE_STAGES];
  logic [SLICE_LUT_K-1:0]  sel [SLICE_STAGES];
  logic [SLICE_STAGES-1:0] lut_o, sum, comb, q, outq;
  logic                    f5, f6;

  slice_cfg_shift #(.W(SLICE_CFG_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (cfg_en_i),
    .bit_i (cfg_bit_i),
    .cfg_o (cfg_vec)
  );

  assign cfg    = slice_cfg_t'(cfg_vec);
  assign tbl[0] = cfg.lut_f;
  assign tbl[1] = cfg.lut_g;
  assign sel[0] = f_in_i;
  assign sel[1] = g_in_i;

  for (genvar e = 0; e < SLICE_STAGES; e++) begin : g_lut
    slice_lut #(.K(SLICE_LUT_K)) u_lut (
      .tbl_i(tbl[e]),
      .sel_i(sel[e]),
      .out_o(lut_o[e])
    );
  end

  assign f5 = f5_sel_i ? lut_o[1] : lut_o[0];
  assign f6 = f6_sel_i ? f5_nbr_i : f5;

  slice_carry #(.N(SLICE_STAGES)) u_carry (
    .prop_i    (lut_o),
    .opa_i     ({g_in_i[0], f_in_i[0]}),
    .opb_i     ({g_in_i[1], f_in_i[1]}),
    .cin_i     (cin_i),
    .mult_en_i (cfg.mult_en),
    .carry_en_i(cfg.carry_en),
    .sum_o     (sum),
    .cout_o    (cout_o)
  );

  // carry path outranks the wide multiplexers
  assign comb[0] = cfg.carry_en ? sum[0] : (cfg.wide5_en ? f5 : lut_o[0]);
  assign comb[1] = cfg.carry_en ? sum[1] : (cfg.wide6_en ? f6 : lut_o[1]);

  for (genvar e = 0; e < SLICE_STAGES; e++) begin : g_store
    slice_store u_store (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (comb[e]),
      .ce_i   (ce_i),
      .sr_i   (sr_i),
      .by_i   (by_i),
      .latch_i(cfg.latch[e]),
      .sync_i (cfg.sync_force),
      .init_i (cfg.init[e]),
      .q_o    (q[e])
    );
    assign outq[e] = cfg.bypass[e] ? comb[e] : q[e];
  end

  assign x_o    = comb[0];
  assign y_o    = comb[1];
  assign xq_o   = outq[0];
  assign yq_o   = outq[1];
  assign f5_o   = f5;
  assign thru_o = thru_i;

  assert_carry_pass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.carry_en && lut_o[0] && lut_o[1]) |-> cout_o == cin_i);
  assert_no_carry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg.carry_en |-> !cout_o);
  assert_wide_sel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.carry_en && cfg.wide5_en && f5_sel_i) |-> x_o == lut_o[1]);
endmodule

// File: tb/tb_logic_slice.sv
`timescale 1ns/1ps
module tb_logic_slice;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic cfg_en = 0, cfg_bit = 0;
  logic [3:0] f_in = 0, g_in = 0, thru_i = 0;
  logic f5_sel = 0, f6_sel = 0, f5_nbr = 0, cin = 0, ce = 0, sr = 0, by = 0;
  logic x_o, y_o, xq_o, yq_o, f5_o, cout_o;
  logic [3:0] thru_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  logic_slice dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_en_i(cfg_en), .cfg_bit_i(cfg_bit),
    .f_in_i(f_in), .g_in_i(g_in), .f5_sel_i(f5_sel), .f6_sel_i(f6_sel),
    .f5_nbr_i(f5_nbr), .cin_i(cin), .ce_i(ce), .sr_i(sr), .by_i(by),
    .thru_i(thru_i), .x_o(x_o), .y_o(y_o), .xq_o(xq_o), .yq_o(yq_o),
    .f5_o(f5_o), .cout_o(cout_o), .thru_o(thru_o)
  );

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [42:0] mk(input logic [15:0] g, input logic [15:0] f,
      input logic w5, input logic w6, input logic cy, input logic mu,
      input logic [1:0] lat, input logic sy, input logic [1:0] ini, input logic [1:0] byp);
    return {g, f, w5, w6, cy, mu, lat, sy, ini, byp};
  endfunction

  task automatic load(input logic [42:0] v);
    for (int i = 42; i >= 0; i--) begin
      @(negedge clk); cfg_en = 1; cfg_bit = v[i];
    end
    @(negedge clk); cfg_en = 0;
  endtask

  function automatic logic [15:0] prod_tbl();
    logic [15:0] t;
    for (int i = 0; i < 16; i++) t[i] = (i[0] & i[1]) ^ (i[2] & i[3]);
    return t;
  endfunction

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] tf, tg, pt;
    logic ex, ey, w5;
    int s0, s1;
    // R11 reset state
    #1;
    chk("R11 x", x_o, 0); chk("R11 y", y_o, 0); chk("R11 xq", xq_o, 0);
    chk("R11 yq", yq_o, 0); chk("R11 cout", cout_o, 0);
    repeat (3) @(negedge clk);
    rst_ni = 1;

    // R10 feedthrough
    for (int i = 0; i < 16; i++) begin
      thru_i = i[3:0]; #0.5; chk("R10 thru", thru_o, i[3:0]);
    end

    // R2 plain tables, R3 f5_o
    tf = 16'hA5C3; tg = 16'h3C96;
    load(mk(tg, tf, 0, 0, 0, 0, 2'b00, 1, 2'b00, 2'b11));
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int s = 0; s < 2; s++) begin
          f_in = a[3:0]; g_in = b[3:0]; f5_sel = s[0]; #0.5;
          chk("R2 x", x_o, tf[a]); chk("R2 y", y_o, tg[b]);
          chk("R3 f5_o", f5_o, s[0] ? tg[b] : tf[a]);
        end

    // R1 hold while cfg_en low
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); cfg_bit = i[0] ^ i[2];
    end
    for (int a = 0; a < 16; a++) begin
      f_in = a[3:0]; g_in = a[3:0]; #0.5;
      chk("R1 hold x", x_o, tf[a]); chk("R1 hold y", y_o, tg[a]);
    end

    // R3/R4 wide multiplexers
    load(mk(tg, tf, 1, 1, 0, 0, 2'b00, 1, 2'b00, 2'b11));
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        for (int m = 0; m < 8; m++) begin
          f_in = a[3:0]; g_in = b[3:0];
          f5_sel = m[0]; f6_sel = m[1]; f5_nbr = m[2]; #0.5;
          w5 = m[0] ? tg[b] : tf[a];
          chk("R3 x", x_o, w5);
          chk("R4 y", y_o, m[1] ? m[2] : w5);
        end

    // R5 adder: tables are in0 ^ in1
    load(mk(16'h6666, 16'h6666, 0, 0, 1, 0, 2'b00, 1, 2'b00, 2'b11));
    for (int i = 0; i < 32; i++) begin
      int sum;
      f_in = {2'b00, i[1], i[0]}; g_in = {2'b00, i[3], i[2]}; cin = i[4]; #0.5;
      sum = {i[2], i[0]} + {i[3], i[1]} + i[4];
      chk("R5 add", {1'b0, cout_o, y_o, x_o}, sum[3:0]);
    end

    // R5 multiply mode: tables are (in0&in1)^(in2&in3)
    pt = prod_tbl();
    load(mk(pt, pt, 0, 0, 1, 1, 2'b00, 1, 2'b00, 2'b11));
    for (int i = 0; i < 512; i++) begin
      f_in = i[3:0]; g_in = i[7:4]; cin = i[8]; #0.5;
      s0 = (i[0] & i[1]) + (i[2] & i[3]) + i[8];
      s1 = (i[4] & i[5]) + (i[6] & i[7]) + s0 / 2;
      chk("R5 mult", {1'b0, cout_o, y_o, x_o}, {1'b0, s1[1], s1[0], s0[0]});
    end
    cin = 0;
    // carry disabled: cout low
    load(mk(16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 2'b00, 1, 2'b00, 2'b11));
    cin = 1; #0.5; chk("R5 no carry", cout_o, 0); cin = 0;

    // R6 flip-flop with enable; tables pass in0
    load(mk(16'hAAAA, 16'hAAAA, 0, 0, 0, 0, 2'b00, 1, 2'b00, 2'b00));
    ce = 1; f_in = 0; g_in = 1;
    @(posedge clk); #1;
    ex = 0; ey = 1;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk); #0.5;
      f_in = {3'b0, i[0] ^ i[2]}; g_in = {3'b0, i[1]}; ce = (i % 3) != 2;
      #0.5;
      chk("R6 no change between edges x", xq_o, ex);
      chk("R6 no change between edges y", yq_o, ey);
      @(posedge clk); #1;
      if (ce) begin ex = i[0] ^ i[2]; ey = i[1]; end
      chk("R6 ff x", xq_o, ex); chk("R6 ff y", yq_o, ey);
    end

    // R8 sync forces; init X=1, Y=0
    load(mk(16'hAAAA, 16'hAAAA, 0, 0, 0, 0, 2'b00, 1, 2'b01, 2'b00));
    ce = 0;
    ex = xq_o; ey = yq_o;
    @(negedge clk); sr = 1; #0.5;
    chk("R8 sync no early x", xq_o, ex);
    @(posedge clk); #1;
    chk("R8 sr x", xq_o, 1); chk("R8 sr y", yq_o, 0);
    @(negedge clk); sr = 0; by = 1;
    @(posedge clk); #1;
    chk("R8 by x", xq_o, 0); chk("R8 by y", yq_o, 1);
    @(negedge clk); sr = 1; by = 1;
    @(posedge clk); #1;
    chk("R8 priority x", xq_o, 1); chk("R8 priority y", yq_o, 0);
    @(negedge clk); sr = 0; by = 0;

    // R9 async forces
    load(mk(16'hAAAA, 16'hAAAA, 0, 0, 0, 0, 2'b00, 0, 2'b01, 2'b00));
    @(negedge clk); #0.5; by = 1; #0.5;
    chk("R9 async by x", xq_o, 0); chk("R9 async by y", yq_o, 1);
    sr = 1; #0.5;
    chk("R9 async priority x", xq_o, 1); chk("R9 async priority y", yq_o, 0);
    @(negedge clk); sr = 0; by = 0;

    // R7 latch mode
    load(mk(16'hAAAA, 16'hAAAA, 0, 0, 0, 0, 2'b11, 1, 2'b00, 2'b00));
    ce = 1; f_in = 1; g_in = 0;
    @(posedge clk); #1;
    chk("R7 open x", xq_o, 1); chk("R7 open y", yq_o, 0);
    f_in = 0; g_in = 1; #0.5;
    chk("R7 follow x", xq_o, 0); chk("R7 follow y", yq_o, 1);
    @(negedge clk); #0.5; f_in = 1; g_in = 0; #0.5;
    chk("R7 closed x", xq_o, 0); chk("R7 closed y", yq_o, 1);
    @(posedge clk); #1;
    chk("R7 reopen x", xq_o, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule